// File: doc/BRIEF.md
# Byte-Level I2C Master Controller

This block is an I2C bus master that a host processor runs one byte at a time through a small 8-bit register file. A single select input picks between two registers. Select 1 takes control words on write and returns status on read. Select 0 is shared between the data byte, the own-address byte and the SCL clock setting. The host asks for START, repeated START and STOP conditions by writing control words. It then feeds or collects each byte through the data register and polls the status register for a pending bit that drops when a byte and its acknowledge slot are done.

SCL and SDA are open-drain: the block drives an output enable that pulls each line low and reads the resolved line levels back. Address and write bytes are shifted out MSB first. The slave's acknowledge is captured in status. In receive mode, each data read hands the host the previous byte and clocks in the next, so the first read after a read address is a dummy. The acknowledge sent for each received byte is chosen in advance by a control bit. A bus monitor watches the real lines to track whether the bus is busy.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status read (select 1) is 0x81, with pending (bit 7) and bus-free (bit 0) set, and both `scl_oe` and `sda_oe` are 0.
- R2: On select 0, control bit 5 set routes reads and writes to the clock register. Otherwise, control bit 6 clear routes them to the own-address register. The two registers keep their values independently.
- R3: A control write with bits 7, 6 and 2 set and bit 1 clear, while idle with the bus free, pulls SDA low with SCL released. It then sends the data register byte MSB first, one bit per SCL pulse.
- R4: Status bit 7 drops to 0 at the end of the ninth SCL pulse of a byte, with SCL held low. It returns to 1 on the data access that starts the next byte.
- R5: Status bit 3 holds the SDA level sampled on the ninth pulse, where 1 means not acknowledged.
- R6: A control write with bit 1 set while waiting between bytes makes SDA rise while SCL is released, and status bit 0 returns to 1.
- R7: A control write with bit 2 set and bit 7 clear while waiting issues a new START without a STOP. A data write made after it is sent as the new address byte.
- R8: Bit 0 of the address byte picks the direction, where 1 means receive. In receive mode, each data read while waiting returns the last byte and starts the next one, so the first read returns the address byte.
- R9: Control bit 0 set makes the block pull SDA low on the ninth pulse of a received byte. Clear, it leaves SDA released, which sends a not-acknowledge.
- R10: A data read made after a STOP request returns the last received byte and produces no further SCL pulses.
- R11: Each SCL low and high phase lasts BASE_HALF >> clock[1:0] system clocks.
- R12: `scl_oe` and `sda_oe` never change in the same cycle. SDA only moves with SCL released as part of a START or STOP.
- R13: Status bit 0 clears when SDA falls with SCL high on the bus and sets when SDA rises with SCL high. A START request made while it is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select: 0 data/own address/clock, 1 control/status |
| wr | input | 1 | Write strobe, one cycle |
| rd | input | 1 | Read strobe, one cycle (side effects on the data register) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| scl_i | input | 1 | Resolved SCL line level |
| sda_i | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Write transfers use data bytes with mixed bits (0xA5), all zeros and all ones. These separate a correct MSB-first shift from a stuck or reversed data line. An unmatched address separates the acknowledge and not-acknowledge paths in the last-received-acknowledge bit. A write-then-read transfer joined by a repeated START exercises several behaviours. It shows that no STOP is emitted in between, that the dummy read returns the address, and that received bytes come back in order. It also shows that the acknowledge control bit flips only the final acknowledge slot. A START faked on the bus by another driver shows that a START request is blocked while the bus is busy.

// File: rtl/i2c_byte_master.sv
`timescale 1ns/1ps
module i2c_byte_master #(
  parameter int BASE_HALF = 250,
  parameter int SEL_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  localparam int CW = $clog2(BASE_HALF + 1);
  localparam logic [3:0] S_IDLE = 4'd0, S_START = 4'd1, S_LOW = 4'd2, S_HIGH = 4'd3,
                         S_HOLD = 4'd4, S_STOP_A = 4'd5, S_STOP_B = 4'd6,
                         S_RS_A = 4'd7, S_RS_B = 4'd8;

  logic [3:0]    st;
  logic [CW-1:0] cnt, half;
  logic [3:0]    bitn;
  logic [7:0]    sr, own, clkr;
  logic          eso, es1, ack_en, pin, nbb, lrb, rx, addr_ph, rs_pend, sda_q;

  assign half   = CW'(BASE_HALF >> clkr[SEL_W-1:0]);
  wire   tick   = (cnt == half - CW'(1));
  wire   midlow = (cnt == CW'(1));
  wire   tx     = addr_ph | ~rx;
  wire   dsel   = !sel && eso && !es1;
  wire   dwr    = wr && dsel;
  wire   drd    = rd && dsel;
  wire   cwr    = wr && sel;
  wire   inbyte = (st == S_LOW) || (st == S_HIGH);
  wire   go     = (st == S_HOLD) && (dwr || (drd && rx && !addr_ph));

  assign scl_oe = (st == S_LOW) || (st == S_HOLD) || (st == S_STOP_A) || (st == S_RS_A);
  assign rdata  = sel ? {pin, 3'b000, lrb, 2'b00, nbb} : es1 ? clkr : eso ? sr : own;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; sr <= '0; own <= '0; clkr <= '0;
      eso <= 1'b0; es1 <= 1'b0; ack_en <= 1'b0; pin <= 1'b1; nbb <= 1'b1;
      lrb <= 1'b0; rx <= 1'b0; addr_ph <= 1'b0; rs_pend <= 1'b0;
      sda_q <= 1'b1; sda_oe <= 1'b0;
    end else begin
      sda_q <= sda_i;
      if (sda_q && !sda_i && scl_i) nbb <= 1'b0;
      else if (!sda_q && sda_i && scl_i) nbb <= 1'b1;

      cnt <= (tick || st == S_IDLE || st == S_HOLD) ? '0 : cnt + CW'(1);

      if (cwr) begin
        eso <= wdata[6]; es1 <= wdata[5]; ack_en <= wdata[0];
        if (wdata[7]) pin <= 1'b1;
      end
      if (wr && !sel) begin
        if (es1) clkr <= wdata;
        else if (!eso) own <= wdata;
      end
      if (dwr && !inbyte) begin
        sr <= wdata;
        rs_pend <= 1'b0;
        if (st != S_IDLE) pin <= 1'b1;
      end

      case (st)
        S_IDLE:
          if (cwr && wdata[7] && wdata[6] && wdata[2] && !wdata[1] && nbb) begin
            st <= S_START; sda_oe <= 1'b1; addr_ph <= 1'b1; rx <= 1'b0; rs_pend <= 1'b0;
          end
        S_START:
          if (tick) begin
            st <= rs_pend ? S_HOLD : S_LOW;
            bitn <= '0;
          end
        S_LOW: begin
          if (midlow) sda_oe <= (bitn == 4'd8) ? (!tx && ack_en) : (tx && !sr[7]);
          if (tick) st <= S_HIGH;
        end
        S_HIGH:
          if (tick) begin
            if (bitn != 4'd8) begin
              sr <= {sr[6:0], sda_i};
              bitn <= bitn + 4'd1;
              st <= S_LOW;
            end else begin
              lrb <= sda_i;
              pin <= 1'b0;
              if (addr_ph) rx <= sr[0];
              addr_ph <= 1'b0;
              st <= S_HOLD;
            end
          end
        S_HOLD:
          if (go) begin
            st <= S_LOW; bitn <= '0; pin <= 1'b1;
          end else if (cwr && wdata[1]) begin
            st <= S_STOP_A;
          end else if (cwr && wdata[2] && !wdata[7]) begin
            st <= S_RS_A; addr_ph <= 1'b1; rx <= 1'b0; rs_pend <= 1'b1;
          end
        S_STOP_A: begin
          if (midlow) sda_oe <= 1'b1;
          if (tick) st <= S_STOP_B;
        end
        S_STOP_B:
          if (tick) begin
            st <= S_IDLE; sda_oe <= 1'b0;
          end
        S_RS_A: begin
          if (midlow) sda_oe <= 1'b0;
          if (tick) st <= S_RS_B;
        end
        S_RS_B:
          if (tick) begin
            st <= S_START; sda_oe <= 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       wr,
  input logic       rd,
  input logic       sel,
  input logic [7:0] wdata,
  input logic       pin,
  input logic       nbb,
  input logic       st_idle
);
  // R12
  line_skew_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_oe) |-> $stable(sda_oe));
  // R4
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin) |-> scl_oe);
  // R4
  pin_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> $past(wr || rd));
  // R6
  bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nbb) |-> !scl_oe);
  // R13
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel && wdata[2] && !wdata[1] && !nbb && st_idle) |=> ($stable(sda_oe) && !scl_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .wr(wr), .rd(rd),
  .sel(sel), .wdata(wdata), .pin(pin), .nbb(nbb), .st_idle(st == 4'd0)
);

// File: tb/tb_i2c_byte_master.sv
`timescale 1ns/1ps
module tb_i2c_byte_master;
  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  wire  [7:0] rdata;
  wire scl_oe, sda_oe;
  logic s_pull = 1'b0, ext_pull = 1'b0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || s_pull || ext_pull);

  always #10 clk = ~clk;

  i2c_byte_master dut (.clk, .rst_n, .sel, .wr, .rd, .wdata, .rdata,
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_oe, .sda_oe);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic reg_wr(input logic s, input logic [7:0] v);
    @(negedge clk); sel = s; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic s, output logic [7:0] v);
    @(negedge clk); sel = s; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_status(input int b, input logic lvl, input string req);
    logic [7:0] s;
    int k;
    k = 0;
    reg_rd(1'b1, s);
    while (s[b] !== lvl && k < 3000) begin reg_rd(1'b1, s); k++; end
    if (k >= 3000) chk(req, s[b], lvl);
  endtask

  // bus-side slave model, stepped away from the active edge
  localparam logic [6:0] SLV = 7'h50;
  logic [7:0] rxlog [16];
  logic       mack [8];
  int rxn = 0, mackn = 0, starts = 0, stops = 0, bitn = 0, tx_idx = 0;
  logic ps_scl = 1, ps_sda = 1, active = 0, in_addr = 0, rd_mode = 0, ack_seen = 0;
  logic [7:0] sh = 0, txb = 0;

  function automatic logic [7:0] rdtab(input int i);
    case (i)
      0: return 8'h96;
      1: return 8'h3C;
      2: return 8'hE7;
      default: return 8'h00;
    endcase
  endfunction

  task slave_step;
    logic c, d;
    c = scl_bus; d = sda_bus;
    if (c && ps_scl && ps_sda && !d) begin
      starts++; active = 1; in_addr = 1; rd_mode = 0; bitn = 0; s_pull = 0;
    end else if (c && ps_scl && !ps_sda && d) begin
      stops++; active = 0; s_pull = 0;
    end else if (active && c && !ps_scl) begin
      if (bitn < 8) sh = {sh[6:0], d}; else ack_seen = d;
      bitn++;
    end else if (active && !c && ps_scl) begin
      if (bitn == 8) begin
        if (in_addr) begin
          rxlog[rxn] = sh; rxn++;
          if (sh[7:1] == SLV) begin rd_mode = sh[0]; s_pull = 1; end
          else active = 0;
        end else if (!rd_mode) begin
          rxlog[rxn] = sh; rxn++; s_pull = 1;
        end else s_pull = 0;
      end else if (bitn == 9) begin
        bitn = 0;
        if (rd_mode && !in_addr) begin mack[mackn] = ack_seen; mackn++; end
        in_addr = 0;
        if (rd_mode && !ack_seen) begin
          txb = rdtab(tx_idx); tx_idx++; s_pull = !txb[7];
        end else s_pull = 0;
      end else if (rd_mode && !in_addr && bitn >= 1 && bitn <= 7) begin
        s_pull = !txb[7-bitn];
      end
    end
    ps_scl = c; ps_sda = d;
  endtask

  initial forever begin @(negedge clk); slave_step(); end

  // R12 watch: both line enables moving in one cycle
  int skew = 0;
  initial begin
    logic pc, pd;
    pc = 0; pd = 0;
    forever begin
      @(negedge clk);
      if (rst_n && scl_oe !== pc && sda_oe !== pd) skew++;
      pc = scl_oe; pd = sda_oe;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk("watchdog expired", 1, 0);
    finish_run();
  end

  // {addr7, data, expect NACK on address}
  localparam int NV = 4;
  localparam logic [15:0] VEC [NV] = '{
    {7'h50, 8'hA5, 1'b0},
    {7'h50, 8'h00, 1'b0},
    {7'h50, 8'hFF, 1'b0},
    {7'h23, 8'h3C, 1'b1}
  };

  initial begin
    logic [7:0] s, v;
    logic [6:0] a;
    logic [7:0] d;
    logic en;
    int base, s0, p0, mb, n, m;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    reg_rd(1'b1, s);
    chk("R1 reset status", s, 8'h81);
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);

    reg_wr(1'b1, 8'h80);
    reg_wr(1'b0, 8'h5A);
    reg_rd(1'b0, v); chk("R2 own address readback", v, 8'h5A);
    reg_wr(1'b1, 8'hA0);
    reg_wr(1'b0, 8'h03);
    reg_rd(1'b0, v); chk("R2 clock register readback", v, 8'h03);
    reg_wr(1'b1, 8'h80);
    reg_rd(1'b0, v); chk("R2 own address kept", v, 8'h5A);
    reg_wr(1'b1, 8'hC1);
    reg_rd(1'b1, s); chk("R1 idle status", s, 8'h81);

    for (int i = 0; i < NV; i++) begin
      a = VEC[i][15:9]; d = VEC[i][8:1]; en = VEC[i][0];
      base = rxn; s0 = starts; p0 = stops;
      reg_wr(1'b0, {a, 1'b0});
      reg_wr(1'b1, 8'hC5);
      reg_rd(1'b1, s);
      chk("R13 bus busy after START", s[0], 0);
      chk("R4 pending during address", s[7], 1);
      if (i == 0) begin
        while (!scl_oe) @(negedge clk);
        n = 0; while (scl_oe) begin n++; @(negedge clk); end
        m = 0; while (!scl_oe) begin m++; @(negedge clk); end
        chk("R11 SCL low phase", n, 31);
        chk("R11 SCL high phase", m, 31);
      end
      wait_status(7, 1'b0, "R4 pending clears after address");
      reg_rd(1'b1, s);
      chk("R5 ack bit after address", s[3], en);
      if (!en) begin
        reg_wr(1'b0, d);
        reg_rd(1'b1, s);
        chk("R4 pending set by data write", s[7], 1);
        wait_status(7, 1'b0, "R4 pending clears after data");
        reg_rd(1'b1, s);
        chk("R5 data acknowledged", s[3], 0);
      end
      reg_wr(1'b1, 8'hC3);
      wait_status(0, 1'b1, "R6 bus free after STOP");
      chk("R3 address byte on bus", rxlog[base], {a, 1'b0});
      if (!en) chk("R3 data byte on bus", rxlog[base+1], d);
      chk("R3 one START", starts - s0, 1);
      chk("R6 one STOP", stops - p0, 1);
    end

    // repeated START into a three-byte read
    base = rxn; s0 = starts; p0 = stops; mb = mackn;
    reg_wr(1'b0, 8'hA0);
    reg_wr(1'b1, 8'hC5);
    wait_status(7, 1'b0, "R4 pending after write address");
    reg_wr(1'b0, 8'h11);
    wait_status(7, 1'b0, "R4 pending after write byte");
    reg_wr(1'b1, 8'h45);
    reg_wr(1'b0, 8'hA1);
    wait_status(7, 1'b0, "R7 pending after read address");
    reg_rd(1'b1, s);
    chk("R7 read address acknowledged", s[3], 0);
    chk("R7 no STOP before repeated START", stops - p0, 0);
    chk("R7 two STARTs", starts - s0, 2);
    chk("R7 address after repeated START", rxlog[base+2], 8'hA1);
    chk("R3 write byte before repeated START", rxlog[base+1], 8'h11);
    reg_rd(1'b0, v); chk("R8 dummy read returns address", v, 8'hA1);
    wait_status(7, 1'b0, "R8 first byte received");
    reg_rd(1'b0, v); chk("R8 first received byte", v, 8'h96);
    wait_status(7, 1'b0, "R8 second byte received");
    reg_wr(1'b1, 8'h40);
    reg_rd(1'b0, v); chk("R8 second received byte", v, 8'h3C);
    wait_status(7, 1'b0, "R8 last byte received");
    reg_rd(1'b1, s); chk("R9 own NACK seen in ack bit", s[3], 1);
    reg_wr(1'b1, 8'hC3);
    reg_rd(1'b0, v); chk("R10 last byte after STOP", v, 8'hE7);
    wait_status(0, 1'b1, "R6 bus free after read");
    n = 0;
    repeat (200) begin @(negedge clk); if (scl_oe) n++; end
    chk("R10 no clocks after final read", n, 0);
    chk("R9 ack on first byte", mack[mb], 0);
    chk("R9 ack on second byte", mack[mb+1], 0);
    chk("R9 NACK on last byte", mack[mb+2], 1);

    // START blocked by a busy bus
    @(negedge clk); ext_pull = 1'b1;
    repeat (5) @(negedge clk);
    reg_rd(1'b1, s); chk("R13 foreign START clears bus-free", s[0], 0);
    reg_wr(1'b1, 8'hC5);
    n = 0;
    repeat (100) begin @(negedge clk); if (scl_oe || sda_oe) n++; end
    chk("R13 START ignored while busy", n, 0);
    ext_pull = 1'b0;
    repeat (5) @(negedge clk);
    reg_rd(1'b1, s); chk("R13 foreign STOP sets bus-free", s[0], 1);

    chk("R12 SCL and SDA never move together", skew, 0);
    finish_run();
  end
endmodule